// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the status word of a small 8/16-bit processor core. The word holds arithmetic flags (carry, zero, overflow, negative) and mode flags (interrupt disable, decimal, index width, data width), plus a 3-bit interrupt priority level. It is read out as a 16-bit word whose top five bits are always zero. The same state also drives individual flag outputs, two width selects and four branch-condition outputs.

Six update sources can write the word: reset, a full-word restore (a pull from the stack), an interrupt-accept strobe, mask-based set/clear commands, single-flag commands for carry and interrupt disable, and per-flag ALU results. In every cycle a selector picks exactly one source, called the update state. The update states are HOLD, ALU, FLAG, MASK, IRQ and RESTORE. A transition into a state happens when its request is the highest one present: RESTORE above IRQ, IRQ above MASK, MASK above FLAG, FLAG above ALU. With no request the selector stays in HOLD. Asynchronous reset overrides all of them. Only the chosen state writes the register on that clock edge. Requests from lower-priority sources in the same cycle are dropped.

Word layout: bit 0 C, bit 1 Z, bit 2 I, bit 3 D, bit 4 X (index width), bit 5 M (data width), bit 6 V, bit 7 N, bits 10:8 priority level, bits 15:11 zero.

Top module: `psw_unit`

## Requirements
- R1: Bits 15:11 of `psw_word` always read as 0. Bits 10:0 follow the layout above.
- R2: While `rst_n` is low, the word is 16'h0004: I=1 and every other bit 0, including D and X.
- R3: When `restore_en` is high, the next word takes `restore_word[10:0]` and ignores `restore_word[15:11]`.
- R4: `irq_take` without restore sets I to 1, loads `irq_level` into bits 10:8 and leaves bits 7:0 other than I unchanged.
- R5: `mask_set_en` ORs `mask_val` into bits 7:0, and `mask_clr_en` clears the bits set in `mask_val`. If both are high, a bit named in the mask ends cleared. Bits 10:8 are unchanged.
- R6: `sec`/`clc` set/clear C, and `sei`/`cli` set/clear I. If set and clear arrive for the same flag, clear wins. Carry and interrupt commands may act together.
- R7: In the ALU state, each of C, V and N loads its ALU value when its write enable is high and is otherwise kept.
- R8: In the ALU state, Z loads `alu_z` when `alu_z_we` is high, unless `dec_add` is high, in which case Z is kept.
- R9: `br_cs`=C, `br_cc`=!C, `br_eq`=Z, `br_ne`=!Z.
- R10: Priority, highest first: reset, restore, interrupt accept, mask commands, single-flag commands, ALU updates. Lower requests in the same cycle have no effect.
- R11: `idx_narrow` equals X and `dat_narrow` equals M. A value of 1 selects 8-bit width and 0 selects 16-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_c_we | input | 1 | Carry write enable |
| alu_c | input | 1 | ALU carry/borrow |
| alu_z_we | input | 1 | Zero write enable |
| alu_z | input | 1 | ALU zero result |
| alu_v_we | input | 1 | Overflow write enable |
| alu_v | input | 1 | ALU overflow |
| alu_n_we | input | 1 | Negative write enable |
| alu_n | input | 1 | ALU negative |
| dec_add | input | 1 | Current ALU update is a decimal addition |
| mask_set_en | input | 1 | Set bits named by mask |
| mask_clr_en | input | 1 | Clear bits named by mask |
| mask_val | input | 8 | Mask over bits 7:0 |
| sec | input | 1 | Set carry |
| clc | input | 1 | Clear carry |
| sei | input | 1 | Set interrupt disable |
| cli | input | 1 | Clear interrupt disable |
| irq_take | input | 1 | Interrupt accepted |
| irq_level | input | 3 | New priority level |
| restore_en | input | 1 | Full-word restore |
| restore_word | input | 16 | Word to restore |
| psw_word | output | 16 | Readable status word |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt disable |
| flag_d | output | 1 | Decimal mode |
| idx_narrow | output | 1 | 1 = 8-bit index registers |
| dat_narrow | output | 1 | 1 = 8-bit data |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| ipl | output | 3 | Interrupt priority level |
| br_cc | output | 1 | Branch on carry clear |
| br_cs | output | 1 | Branch on carry set |
| br_ne | output | 1 | Branch on not equal |
| br_eq | output | 1 | Branch on equal |

## Verification
An interrupt acceptance can arrive in the same cycle as a `cli` or a mask clear of bit 2, and it must win so that I ends at 1. An ALU zero update can coincide with a decimal-add cycle. The bench drives these pairs on purpose in directed steps. It also drives random cycles in which every request line toggles independently, so any two sources collide often. A behavioural model picks the single winning source and computes the expected word. The model is compared with the whole word, every flag, the width selects and the branch outputs after each edge.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int PSW_W  = 16;
    localparam int LIVE_W = 11;
    localparam int MASK_W = 8;
    localparam int IPL_W  = 3;

    localparam int B_C   = 0;
    localparam int B_Z   = 1;
    localparam int B_I   = 2;
    localparam int B_D   = 3;
    localparam int B_X   = 4;
    localparam int B_M   = 5;
    localparam int B_V   = 6;
    localparam int B_N   = 7;
    localparam int B_IPL = 8;

    localparam logic [LIVE_W-1:0] RESET_VAL = 11'h004;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_ALU,
        SRC_FLAG,
        SRC_MASK,
        SRC_IRQ,
        SRC_RESTORE
    } upd_src_e;

    typedef struct packed {
        logic c_we;
        logic c;
        logic z_we;
        logic z;
        logic v_we;
        logic v;
        logic n_we;
        logic n;
        logic dec_add;
    } alu_upd_t;
endpackage

// File: rtl/psw_src_select.sv
module psw_src_select
    import psw_pkg::*;
(
    input  logic     restore_en,
    input  logic     irq_take,
    input  logic     mask_any,
    input  logic     flag_any,
    input  logic     alu_any,
    output upd_src_e src
);
    always_comb begin
        if (restore_en)    src = SRC_RESTORE;
        else if (irq_take) src = SRC_IRQ;
        else if (mask_any) src = SRC_MASK;
        else if (flag_any) src = SRC_FLAG;
        else if (alu_any)  src = SRC_ALU;
        else               src = SRC_HOLD;
    end

    // Exactly one source wins; a restore request always wins.
    always_comb begin
        if (restore_en) begin
            AST_RESTORE_WINS: assert (src == SRC_RESTORE); // R10
        end
    end
endmodule

// File: rtl/psw_next.sv
module psw_next
    import psw_pkg::*;
#(
    parameter int LW = psw_pkg::LIVE_W,
    parameter int MW = psw_pkg::MASK_W,
    parameter int PW = psw_pkg::IPL_W
) (
    input  upd_src_e      src,
    input  logic [LW-1:0] cur,
    input  logic [LW-1:0] restore_live,
    input  logic [PW-1:0] irq_level,
    input  logic          mask_set_en,
    input  logic          mask_clr_en,
    input  logic [MW-1:0] mask_val,
    input  logic          sec,
    input  logic          clc,
    input  logic          sei,
    input  logic          cli,
    input  alu_upd_t      alu,
    output logic [LW-1:0] nxt
);
    logic [MW-1:0] masked;

    // Per-bit mask cell: set first, then clear, so clear dominates.
    for (genvar b = 0; b < MW; b++) begin : g_mask
        always_comb begin
            masked[b] = cur[b];
            if (mask_set_en && mask_val[b]) masked[b] = 1'b1;
            if (mask_clr_en && mask_val[b]) masked[b] = 1'b0;
        end
    end

    always_comb begin
        nxt = cur;
        unique case (src)
            SRC_RESTORE: nxt = restore_live;
            SRC_IRQ: begin
                nxt[B_I] = 1'b1;
                nxt[B_IPL +: PW] = irq_level;
            end
            SRC_MASK: nxt[MW-1:0] = masked;
            SRC_FLAG: begin
                if (sec) nxt[B_C] = 1'b1;
                if (clc) nxt[B_C] = 1'b0;
                if (sei) nxt[B_I] = 1'b1;
                if (cli) nxt[B_I] = 1'b0;
            end
            SRC_ALU: begin
                if (alu.c_we) nxt[B_C] = alu.c;
                if (alu.z_we && !alu.dec_add) nxt[B_Z] = alu.z;
                if (alu.v_we) nxt[B_V] = alu.v;
                if (alu.n_we) nxt[B_N] = alu.n;
            end
            SRC_HOLD: nxt = cur;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/psw_branch.sv
module psw_branch (
    input  logic c,
    input  logic z,
    output logic br_cc,
    output logic br_cs,
    output logic br_ne,
    output logic br_eq
);
    always_comb begin
        br_cs = c;
        br_cc = ~c;
        br_eq = z;
        br_ne = ~z;
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter int W  = psw_pkg::PSW_W,
    parameter int LW = psw_pkg::LIVE_W,
    parameter int MW = psw_pkg::MASK_W,
    parameter int PW = psw_pkg::IPL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_c_we,
    input  logic          alu_c,
    input  logic          alu_z_we,
    input  logic          alu_z,
    input  logic          alu_v_we,
    input  logic          alu_v,
    input  logic          alu_n_we,
    input  logic          alu_n,
    input  logic          dec_add,
    input  logic          mask_set_en,
    input  logic          mask_clr_en,
    input  logic [MW-1:0] mask_val,
    input  logic          sec,
    input  logic          clc,
    input  logic          sei,
    input  logic          cli,
    input  logic          irq_take,
    input  logic [PW-1:0] irq_level,
    input  logic          restore_en,
    input  logic [W-1:0]  restore_word,
    output logic [W-1:0]  psw_word,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_i,
    output logic          flag_d,
    output logic          idx_narrow,
    output logic          dat_narrow,
    output logic          flag_v,
    output logic          flag_n,
    output logic [PW-1:0] ipl,
    output logic          br_cc,
    output logic          br_cs,
    output logic          br_ne,
    output logic          br_eq
);
    localparam int PAD_W = W - LW;

    upd_src_e      src;
    alu_upd_t      alu;
    logic [LW-1:0] psw_q;
    logic [LW-1:0] psw_d;
    logic          unused_hi;

    assign unused_hi = ^restore_word[W-1:LW];

    assign alu = '{c_we: alu_c_we, c: alu_c, z_we: alu_z_we, z: alu_z,
                   v_we: alu_v_we, v: alu_v, n_we: alu_n_we, n: alu_n,
                   dec_add: dec_add};

    psw_src_select u_sel (
        .restore_en (restore_en),
        .irq_take   (irq_take),
        .mask_any   (mask_set_en | mask_clr_en),
        .flag_any   (sec | clc | sei | cli),
        .alu_any    (alu_c_we | alu_z_we | alu_v_we | alu_n_we),
        .src        (src)
    );

    psw_next #(.LW(LW), .MW(MW), .PW(PW)) u_next (
        .src          (src),
        .cur          (psw_q),
        .restore_live (restore_word[LW-1:0]),
        .irq_level    (irq_level),
        .mask_set_en  (mask_set_en),
        .mask_clr_en  (mask_clr_en),
        .mask_val     (mask_val),
        .sec          (sec),
        .clc          (clc),
        .sei          (sei),
        .cli          (cli),
        .alu          (alu),
        .nxt          (psw_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psw_q <= RESET_VAL;
        else        psw_q <= psw_d;
    end

    // Outputs
    always_comb begin
        psw_word   = {{PAD_W{1'b0}}, psw_q};
        flag_c     = psw_q[B_C];
        flag_z     = psw_q[B_Z];
        flag_i     = psw_q[B_I];
        flag_d     = psw_q[B_D];
        idx_narrow = psw_q[B_X];
        dat_narrow = psw_q[B_M];
        flag_v     = psw_q[B_V];
        flag_n     = psw_q[B_N];
        ipl        = psw_q[B_IPL +: PW];
    end

    psw_branch u_br (
        .c     (psw_q[B_C]),
        .z     (psw_q[B_Z]),
        .br_cc (br_cc),
        .br_cs (br_cs),
        .br_ne (br_ne),
        .br_eq (br_eq)
    );

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psw_word[W-1:LW] == '0); // R1
    AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> psw_word[LW-1:0] == $past(restore_word[LW-1:0])); // R3
    AST_IRQ_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !restore_en) |=> (flag_i && ipl == $past(irq_level))); // R4
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set_en && !mask_clr_en && !restore_en && !irq_take)
        |=> ((psw_word[MW-1:0] & $past(mask_val)) == $past(mask_val))); // R5
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr_en && !restore_en && !irq_take)
        |=> ((psw_word[MW-1:0] & $past(mask_val)) == '0)); // R5
    AST_CLC: assert property (@(posedge clk) disable iff (!rst_n)
        (clc && !restore_en && !irq_take && !mask_set_en && !mask_clr_en)
        |=> !flag_c); // R6
    AST_ALU_V: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_ALU && alu_v_we) |=> flag_v == $past(alu_v)); // R7
    AST_DEC_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_ALU && dec_add) |=> $stable(flag_z)); // R8
    AST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_cs == flag_c && br_cc != flag_c && br_eq == flag_z && br_ne != flag_z)); // R9
    AST_WIDTH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_narrow == psw_word[4] && dat_narrow == psw_word[5])); // R11
endmodule

// File: tb/sim_psw_unit.sv
module sim_psw_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic alu_c_we = 0, alu_c = 0, alu_z_we = 0, alu_z = 0;
    logic alu_v_we = 0, alu_v = 0, alu_n_we = 0, alu_n = 0, dec_add = 0;
    logic mask_set_en = 0, mask_clr_en = 0;
    logic [7:0] mask_val = 0;
    logic sec = 0, clc = 0, sei = 0, cli = 0;
    logic irq_take = 0;
    logic [2:0] irq_level = 0;
    logic restore_en = 0;
    logic [15:0] restore_word = 0;

    logic [15:0] psw_word;
    logic flag_c, flag_z, flag_i, flag_d, idx_narrow, dat_narrow, flag_v, flag_n;
    logic [2:0] ipl;
    logic br_cc, br_cs, br_ne, br_eq;

    int checks = 0;
    int errors = 0;
    int exp_w = 16'h0004;

    psw_unit u0 (.*);

    function automatic int model(int w);
        int r = w;
        if (restore_en) r = restore_word % 2048;
        else if (irq_take) r = (w % 256) - (w % 256 / 4 % 2) * 4 + 4 + irq_level * 256;
        else if (mask_set_en || mask_clr_en) begin
            int lo = w % 256;
            if (mask_set_en) lo = lo | mask_val;
            if (mask_clr_en) lo = lo & ~int'(mask_val) & 255;
            r = (w / 256) * 256 + lo;
        end else if (sec || clc || sei || cli) begin
            if (sec) r = r | 1;
            if (clc) r = r & ~1;
            if (sei) r = r | 4;
            if (cli) r = r & ~4;
        end else begin
            if (alu_c_we) r = alu_c ? (r | 1) : (r & ~1);
            if (alu_z_we && !dec_add) r = alu_z ? (r | 2) : (r & ~2);
            if (alu_v_we) r = alu_v ? (r | 64) : (r & ~64);
            if (alu_n_we) r = alu_n ? (r | 128) : (r & ~128);
        end
        return r;
    endfunction

    task automatic compare(string tag);
        int got = {psw_word, flag_c, flag_z, flag_i, flag_d, idx_narrow, dat_narrow,
                   flag_v, flag_n, ipl, br_cc, br_cs, br_ne, br_eq};
        logic [15:0] e = exp_w[15:0];
        int want = {e, e[0], e[1], e[2], e[3], e[4], e[5], e[6], e[7], e[10:8],
                    ~e[0], e[0], ~e[1], e[1]};
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: word=%h actual=%h expected=%h", tag, psw_word, got, want);
        end
    endtask

    task automatic quiet();
        {alu_c_we, alu_c, alu_z_we, alu_z, alu_v_we, alu_v, alu_n_we, alu_n, dec_add} = '0;
        {mask_set_en, mask_clr_en, sec, clc, sei, cli, irq_take, restore_en} = '0;
        mask_val = 0; irq_level = 0; restore_word = 0;
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        exp_w = model(exp_w);
        #1;
        compare(tag);
        quiet();
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        quiet();
        #9;
        compare("R2 reset value");
        rst_n = 1'b1;
        cyc("R2 hold after reset");
        restore_en = 1; restore_word = 16'hFFFF;
        cyc("R1 R3 restore upper ignored");
        restore_en = 1; restore_word = 16'h0000; irq_take = 1; irq_level = 3'd6;
        mask_set_en = 1; mask_val = 8'h30;
        cyc("R10 restore over irq and mask");
        mask_set_en = 1; mask_val = 8'hFF; sec = 1;
        cyc("R5 R11 mask set with widths narrow");
        mask_clr_en = 1; mask_val = 8'h0F;
        cyc("R5 mask clear");
        mask_set_en = 1; mask_clr_en = 1; mask_val = 8'h81;
        cyc("R5 set and clear together");
        sec = 1; sei = 1;
        cyc("R6 R9 set carry and I");
        sec = 1; clc = 1; cli = 1;
        cyc("R6 clear dominates");
        irq_take = 1; irq_level = 3'd5; cli = 1; mask_clr_en = 1; mask_val = 8'h04;
        cyc("R4 R10 irq over cli and mask");
        alu_c_we = 1; alu_c = 1; alu_z_we = 1; alu_z = 1;
        alu_v_we = 1; alu_v = 1; alu_n_we = 1; alu_n = 1;
        cyc("R7 R8 R9 alu load all");
        alu_z_we = 1; alu_z = 0; dec_add = 1; alu_c_we = 1; alu_c = 0;
        cyc("R8 decimal add keeps zero");
        alu_v_we = 0; alu_v = 0; alu_n_we = 1; alu_n = 0; alu_z_we = 1; alu_z = 0;
        cyc("R7 R8 partial enables");
        clc = 1; alu_c_we = 1; alu_c = 1;
        cyc("R10 flag command over alu");
        mask_clr_en = 1; mask_val = 8'h30;
        cyc("R11 widths wide");
        for (int k = 0; k < 400; k++) begin
            int rr = $urandom;
            restore_en = ($urandom % 16) == 0; restore_word = rr[15:0];
            irq_take = ($urandom % 8) == 0; irq_level = rr[18:16];
            mask_set_en = ($urandom % 6) == 0; mask_clr_en = ($urandom % 6) == 0;
            mask_val = rr[26:19];
            {sec, clc, sei, cli} = 4'($urandom % 16 < 6 ? $urandom : 0);
            {alu_c_we, alu_c, alu_z_we, alu_z, alu_v_we, alu_v, alu_n_we, alu_n, dec_add}
                = 9'($urandom);
            cyc("R10 random collisions");
        end
        rst_n = 1'b0;
        #1;
        exp_w = 16'h0004;
        compare("R2 reset reapplied");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule